// File: doc/BRIEF.md
# Dual-Slot Ethernet Receive Framer

This block takes an incoming Ethernet payload as a byte stream and stores a complete wire-format frame into one of two receive buffers. Each buffer is a slot that software arms before it can be used. The stored image starts with the regenerated 8-byte preamble and start delimiter. The payload follows, zero-padded up to the minimum payload length. A CRC-32 frame check sequence closes the image. When a frame is finished, the block records its byte count, marks the slot as holding a frame and raises a level interrupt.

The two slots provide all the flow control. A frame goes to slot 0 if software has armed it, and to slot 1 otherwise. While no slot is armed the stream input is held off. A payload too large for a buffer is consumed and thrown away, and the slot stays armed. Software reads stored frames through a synchronous byte read port. It frees a slot, or arms it again, by writing its state.

Top module: `dual_slot_rx_framer`

## Requirements
- R1: Each slot state reads as 0 (empty), 1 (armed) or 2 (holding a frame). A software write sets the addressed slot's state, a written value of 3 is stored as 0, and after reset both states and both counts are 0.
- R2: A new frame is placed in slot 0 if it is armed, otherwise in slot 1. While neither slot is armed, `in_ready` stays low and no slot changes.
- R3: Buffer offsets 0 to 6 hold 0x55, offset 7 holds 0xD5, and payload byte i is stored at offset 8+i.
- R4: A payload shorter than MIN_PAYLOAD bytes is followed by zero bytes up to MIN_PAYLOAD bytes.
- R5: The four bytes after the padded payload hold the complement of the reflected CRC-32 (polynomial 0x04C11DB7, all-ones start) over the padded payload only, lowest byte first.
- R6: When a frame completes, its slot count becomes the padded payload length plus 12 and its state becomes 2.
- R7: A payload longer than BUF_BYTES-12 bytes is accepted up to its last byte and then discarded. Its slot stays at state 1 and the slot count keeps its previous value.
- R8: `rx_irq` is high exactly while at least one slot state is 2. It follows software state writes in the same cycle as the state outputs.
- R9: `rd_data` shows the byte at offset `rd_addr` of slot `rd_slot` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| st_we | input | 1 | Slot state write strobe |
| st_slot | input | 1 | Slot addressed by the state write |
| st_value | input | 2 | State value written |
| rd_slot | input | 1 | Slot selected for buffer read |
| rd_addr | input | log2(BUF_BYTES) | Byte offset in the selected buffer |
| rd_data | output | 8 | Buffer byte, one cycle after the address |
| slot0_state | output | 2 | Slot 0 state |
| slot1_state | output | 2 | Slot 1 state |
| slot0_count | output | log2(BUF_BYTES+1) | Slot 0 stored byte count |
| slot1_count | output | log2(BUF_BYTES+1) | Slot 1 stored byte count |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
The assertions assume that software never writes the state of the slot being filled while a frame is in flight, and never writes state 2 itself. They also assume that bytes are only offered with in_valid. The bench keeps to these rules. It changes slot states only between frames, and only to empty or armed. It arms either a single slot or both slots before a frame starts, and it sweeps every payload length up to the buffer limit in a small buffer configuration.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_st_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_PRE,
    W_PAY,
    W_PAD,
    W_FCS
  } wr_st_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam int          WRAP_BYTES    = 12;

  // one byte of reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fr_crc32.sv
module fr_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import fr_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc32_step(crc_q, din);
    end
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/fr_frame_ram.sv
module fr_frame_ram #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fr_slot_ctrl.sv
module fr_slot_ctrl #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic          sw_slot,
  input  logic [1:0]    sw_state,
  input  logic          commit,
  input  logic          commit_slot,
  input  logic [CW-1:0] commit_count,
  output logic [3:0]    state_o,
  output logic [2*CW-1:0] count_o,
  output logic          irq_o
);
  import fr_pkg::*;

  logic [1:0] pend_nx;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    slot_st_e      st_q;
    slot_st_e      st_nx;
    logic [CW-1:0] cnt_q;
    logic          sel_sw;
    logic          sel_cm;

    assign sel_sw = sw_we && (sw_slot == 1'(g));
    assign sel_cm = commit && (commit_slot == 1'(g));

    always_comb begin
      st_nx = st_q;
      if (sel_sw) begin
        st_nx = (sw_state == 2'd3) ? SLOT_EMPTY : slot_st_e'(sw_state);
      end
      if (sel_cm) begin
        st_nx = SLOT_PENDING;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q  <= SLOT_EMPTY;
        cnt_q <= '0;
      end else begin
        st_q <= st_nx;
        if (sel_cm) begin
          cnt_q <= commit_count;
        end
      end
    end

    assign pend_nx[g]          = (st_nx == SLOT_PENDING);
    assign state_o[2*g +: 2]   = st_q;
    assign count_o[CW*g +: CW] = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |pend_nx;
    end
  end

endmodule

// File: rtl/dual_slot_rx_framer.sv
module dual_slot_rx_framer #(
  parameter int BUF_BYTES   = 2048,
  parameter int MIN_PAYLOAD = 60,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          st_we,
  input  logic          st_slot,
  input  logic [1:0]    st_value,
  input  logic          rd_slot,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [1:0]    slot0_state,
  output logic [1:0]    slot1_state,
  output logic [CW-1:0] slot0_count,
  output logic [CW-1:0] slot1_count,
  output logic          rx_irq
);
  import fr_pkg::*;

  localparam logic [CW-1:0] MAX_PAY = CW'(BUF_BYTES - WRAP_BYTES);
  localparam logic [CW-1:0] MIN_PAY = CW'(MIN_PAYLOAD);

  wr_st_e        st_q, st_d;
  logic          slot_q, slot_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] len_q, len_d, len_inc;
  logic [2:0]    idx_q, idx_d;
  logic          drop_q, drop_d;

  logic          wr_en;
  logic [7:0]    wr_data;
  logic          crc_init, crc_en;
  logic [7:0]    crc_din;
  logic [31:0]   fcs;
  logic          commit;
  logic [3:0]    states;
  logic [2*CW-1:0] counts;
  logic          s0_armed, s1_armed;

  assign slot0_state = states[1:0];
  assign slot1_state = states[3:2];
  assign slot0_count = counts[CW-1:0];
  assign slot1_count = counts[2*CW-1:CW];
  assign s0_armed    = (slot0_state == SLOT_LOADED);
  assign s1_armed    = (slot1_state == SLOT_LOADED);
  assign len_inc     = len_q + 1'b1;

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    ptr_d    = ptr_q;
    len_d    = len_q;
    idx_d    = idx_q;
    drop_d   = drop_q;
    wr_en    = 1'b0;
    wr_data  = 8'h00;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    crc_din  = 8'h00;
    commit   = 1'b0;
    in_ready = (st_q == W_PAY);
    unique case (st_q)
      W_IDLE: begin
        if (in_valid && (s0_armed || s1_armed)) begin
          st_d     = W_PRE;
          slot_d   = !s0_armed;
          ptr_d    = '0;
          len_d    = '0;
          idx_d    = '0;
          drop_d   = 1'b0;
          crc_init = 1'b1;
        end
      end
      W_PRE: begin
        wr_en   = 1'b1;
        wr_data = (idx_q == 3'd7) ? SFD_BYTE : PRE_BYTE;
        ptr_d   = ptr_q + 1'b1;
        idx_d   = idx_q + 1'b1;
        if (idx_q == 3'd7) begin
          st_d = W_PAY;
        end
      end
      W_PAY: begin
        if (in_valid) begin
          if (!drop_q && (len_q < MAX_PAY)) begin
            wr_en   = 1'b1;
            wr_data = in_data;
            crc_en  = 1'b1;
            crc_din = in_data;
            ptr_d   = ptr_q + 1'b1;
            len_d   = len_inc;
          end else begin
            drop_d = 1'b1;
          end
          if (in_last) begin
            idx_d = '0;
            if (drop_q || (len_q >= MAX_PAY)) begin
              st_d = W_IDLE;
            end else if (len_inc < MIN_PAY) begin
              st_d = W_PAD;
            end else begin
              st_d = W_FCS;
            end
          end
        end
      end
      W_PAD: begin
        wr_en   = 1'b1;
        crc_en  = 1'b1;
        ptr_d   = ptr_q + 1'b1;
        len_d   = len_inc;
        if (len_inc >= MIN_PAY) begin
          st_d = W_FCS;
        end
      end
      W_FCS: begin
        wr_en   = 1'b1;
        wr_data = fcs[{idx_q[1:0], 3'b000} +: 8];
        ptr_d   = ptr_q + 1'b1;
        idx_d   = idx_q + 1'b1;
        if (idx_q[1:0] == 2'd3) begin
          commit = 1'b1;
          st_d   = W_IDLE;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= W_IDLE;
      slot_q <= 1'b0;
      ptr_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      ptr_q  <= ptr_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      drop_q <= drop_d;
    end
  end

  fr_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .en   (crc_en),
    .din  (crc_din),
    .fcs  (fcs)
  );

  fr_frame_ram #(.DEPTH(2 * BUF_BYTES)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({slot_q, ptr_q}),
    .wdata (wr_data),
    .raddr ({rd_slot, rd_addr}),
    .rdata (rd_data)
  );

  fr_slot_ctrl #(.CW(CW)) u_slots (
    .clk          (clk),
    .rst          (rst),
    .sw_we        (st_we),
    .sw_slot      (st_slot),
    .sw_state     (st_value),
    .commit       (commit),
    .commit_slot  (slot_q),
    .commit_count (len_q + CW'(WRAP_BYTES)),
    .state_o      (states),
    .count_o      (counts),
    .irq_o        (rx_irq)
  );

endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int BUF_BYTES   = 2048,
  parameter int MIN_PAYLOAD = 60,
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic [1:0]    slot0_state,
  input logic [1:0]    slot1_state,
  input logic [CW-1:0] slot0_count,
  input logic [CW-1:0] slot1_count,
  input logic          rx_irq
);

  localparam logic [CW-1:0] CNT_MIN = CW'(MIN_PAYLOAD + 12);
  localparam logic [CW-1:0] CNT_MAX = CW'(BUF_BYTES);

  a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
    (slot0_state != 2'd3) && (slot1_state != 2'd3));

  a_r2_ready_needs_arm: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> ((slot0_state == 2'd1) || (slot1_state == 2'd1)));

  a_r6_count0_range: assert property (@(posedge clk) disable iff (rst)
    (slot0_count != '0) |-> ((slot0_count >= CNT_MIN) && (slot0_count <= CNT_MAX)));

  a_r6_count1_range: assert property (@(posedge clk) disable iff (rst)
    (slot1_count != '0) |-> ((slot1_count >= CNT_MIN) && (slot1_count <= CNT_MAX)));

  a_r7_count0_with_pend: assert property (@(posedge clk) disable iff (rst)
    (slot0_count != $past(slot0_count)) |-> (slot0_state == 2'd2));

  a_r7_count1_with_pend: assert property (@(posedge clk) disable iff (rst)
    (slot1_count != $past(slot1_count)) |-> (slot1_state == 2'd2));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    rx_irq == ((slot0_state == 2'd2) || (slot1_state == 2'd2)));

endmodule

bind dual_slot_rx_framer fr_checker #(
  .BUF_BYTES   (BUF_BYTES),
  .MIN_PAYLOAD (MIN_PAYLOAD)
) u_fr_checker (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .slot0_state (slot0_state),
  .slot1_state (slot1_state),
  .slot0_count (slot0_count),
  .slot1_count (slot1_count),
  .rx_irq      (rx_irq)
);

// File: tb/dual_slot_rx_framer_test.sv
module dual_slot_rx_framer_test;

  localparam int BUF = 128;
  localparam int MINP = 60;
  localparam int AW = $clog2(BUF);
  localparam int CW = $clog2(BUF + 1);
  localparam int MAXP = BUF - 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_last = 1'b0;
  logic          in_ready;
  logic          st_we = 1'b0;
  logic          st_slot = 1'b0;
  logic [1:0]    st_value = 2'd0;
  logic          rd_slot = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [1:0]    slot0_state, slot1_state;
  logic [CW-1:0] slot0_count, slot1_count;
  logic          rx_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_slot_rx_framer #(.BUF_BYTES(BUF), .MIN_PAYLOAD(MINP)) uut (
    .clk, .rst, .in_valid, .in_data, .in_last, .in_ready,
    .st_we, .st_slot, .st_value, .rd_slot, .rd_addr, .rd_data,
    .slot0_state, .slot1_state, .slot0_count, .slot1_count, .rx_irq
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(input int i, input int len);
    return 8'((i * 7 + len * 13 + 1) & 255);
  endfunction

  function automatic int padded(input int len);
    return (len < MINP) ? MINP : len;
  endfunction

  function automatic logic [31:0] fcs_of(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < padded(len); i++) begin
      c = c ^ {24'd0, (i < len) ? pay_byte(i, len) : 8'h00};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic int st_of(input bit s);
    return s ? int'(slot1_state) : int'(slot0_state);
  endfunction

  function automatic int cnt_of(input bit s);
    return s ? int'(slot1_count) : int'(slot0_count);
  endfunction

  task automatic set_state(input bit s, input logic [1:0] v);
    @(negedge clk);
    st_we = 1'b1; st_slot = s; st_value = v;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pay_byte(i, len); in_last = (i == len - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_pending(input bit s);
    while (st_of(s) != 2) @(negedge clk);
  endtask

  task automatic read_byte(input bit s, input int a, output int v);
    @(negedge clk);
    rd_slot = s; rd_addr = AW'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic check_frame(input bit s, input int len);
    int p = padded(len);
    logic [31:0] f = fcs_of(len);
    int v, e;
    chk(cnt_of(s) == p + 12, "R6 count", cnt_of(s), p + 12);
    for (int a = 0; a < p + 12; a++) begin
      read_byte(s, a, v);
      if (a < 7) begin
        chk(v == 8'h55, "R3/R9 preamble", v, 8'h55);
      end else if (a == 7) begin
        chk(v == 8'hD5, "R3 sfd", v, 8'hD5);
      end else if (a < 8 + len) begin
        e = int'(pay_byte(a - 8, len));
        chk(v == e, "R3 payload", v, e);
      end else if (a < 8 + p) begin
        chk(v == 0, "R4 pad", v, 0);
      end else begin
        e = int'(f[(a - 8 - p) * 8 +: 8]);
        chk(v == e, "R5 fcs", v, e);
      end
    end
  endtask

  initial begin
    int lp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(slot0_state == 0 && slot1_state == 0, "R1 reset states", st_of(0) + st_of(1), 0);
    chk(slot0_count == 0 && slot1_count == 0, "R1 reset counts", cnt_of(0) + cnt_of(1), 0);
    chk(rx_irq == 0, "R8 reset irq", rx_irq, 0);

    // R2 hold-off with no armed slot
    in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      chk(in_ready == 0, "R2 no slot ready", in_ready, 0);
    end
    chk(slot0_state == 0 && slot1_state == 0, "R2 no slot states", st_of(0) + st_of(1), 0);
    in_valid = 1'b0; in_last = 1'b0;

    // R1 reserved value stored as empty
    set_state(1'b1, 2'd3);
    chk(slot1_state == 0, "R1 value3", st_of(1), 0);
    set_state(1'b0, 2'd1);
    chk(slot0_state == 1, "R1 arm", st_of(0), 1);
    set_state(1'b0, 2'd0);

    // sweep every legal payload length, alternating slots
    for (int len = 1; len <= MAXP; len++) begin
      bit s = len[0];
      set_state(s, 2'd1);
      send_frame(len);
      wait_pending(s);
      @(negedge clk);
      chk(st_of(!s) == 0, "R2 other slot untouched", st_of(!s), 0);
      chk(rx_irq == 1, "R8 irq high", rx_irq, 1);
      check_frame(s, len);
      set_state(s, 2'd0);
      chk(rx_irq == 0, "R8 irq low after clear", rx_irq, 0);
    end

    // R7 oversize drops, slot 0 last held a 116-byte payload (count 128)
    set_state(1'b0, 2'd1);
    lp = MAXP + 1;
    send_frame(lp);
    repeat (3) @(negedge clk);
    chk(slot0_state == 1, "R7 stays armed", st_of(0), 1);
    chk(slot0_count == 128, "R7 count kept", cnt_of(0), 128);
    chk(rx_irq == 0, "R7 no irq", rx_irq, 0);
    send_frame(200);
    repeat (3) @(negedge clk);
    chk(slot0_state == 1, "R7 stays armed long", st_of(0), 1);
    send_frame(65);
    wait_pending(1'b0);
    @(negedge clk);
    check_frame(1'b0, 65);
    set_state(1'b0, 2'd0);

    // R2 priority with both slots armed
    set_state(1'b1, 2'd1);
    set_state(1'b0, 2'd1);
    send_frame(70);
    wait_pending(1'b0);
    @(negedge clk);
    chk(slot1_state == 1, "R2 slot0 first", st_of(1), 1);
    send_frame(61);
    wait_pending(1'b1);
    @(negedge clk);
    check_frame(1'b0, 70);
    check_frame(1'b1, 61);
    in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      chk(in_ready == 0, "R2 both full hold", in_ready, 0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    set_state(1'b0, 2'd0);
    chk(rx_irq == 1, "R8 irq with one pending", rx_irq, 1);
    set_state(1'b1, 2'd0);
    chk(rx_irq == 0, "R8 irq none pending", rx_irq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule